// File: doc/BRIEF.md
# Logarithmic-Domain Unsigned Adder

This block adds two positive quantities that are each held as a base-2 logarithm. A value x is carried as y with x = 2^y. The sum is formed without leaving the log domain: the result is the larger logarithm plus a correction log2(1 + 2^-d), where d is the distance between the two logarithms. The correction is read from a sectioned table built at elaboration. By default each section also stores a slope, and the block interpolates linearly inside the section. A parameter selects a table-only variant, which gives up the multiply and subtract for a coarser result. Each operand word also carries a flag that marks the value zero, which has no logarithm. These zero cases bypass the arithmetic.

Operand pairs enter on a valid/ready stream and results leave in order on a second stream. The pipeline advances as a single unit. When the last stage holds a result that the consumer has not taken, every stage freezes and `in_ready` falls. While the consumer keeps `out_ready` high, one pair is accepted on every clock. A producer may hold `in_valid` high for as long as it likes. A pair moves only on a clock edge where both `in_valid` and `in_ready` are high. A result leaves only on an edge where both `out_valid` and `out_ready` are high.

Top module: `lns_add`

## Requirements
- R1: A word is W = EXP_W+MAN_W+2 bits wide. Bit W-1 is the sign, bit W-2 is the non-zero flag, and bits W-3:0 hold the logarithm as a two's-complement fixed-point number with MAN_W fraction bits (defaults 7+8, so a 17-bit word). When both operands are non-zero, the output has the non-zero flag set. Its sign is that of the operand with the larger logarithm, and operand A wins a tie.
- R2: When both flags are set, the output logarithm lies within one LSB of round(2^MAN_W · log2(2^a + 2^b)), where a and b are the operand logarithms.
- R3: When exactly one flag is set, the output word equals that operand word bit for bit.
- R4: When both flags are clear, the output word is all zeros.
- R5: When the distance is at least 2^(clog2(MAN_W+2)+MAN_W) LSBs (4096 by default), the output logarithm equals the larger logarithm exactly.
- R6: When both operands are non-zero with equal logarithms, the output logarithm is exactly the input plus 2^MAN_W (that is, +1.0).
- R7: A sum above the largest positive logarithm saturates to that largest value.
- R8: With `out_ready` held high, a result becomes valid after the PIPE-th rising edge, counting the edge that accepts the pair as the first. Results leave in the order their pairs were accepted.
- R9: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. While stalled, `out_word` and `out_valid` keep their values.
- R10: During reset and right after it, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take a pair this cycle |
| in_a | input | W | Operand A word |
| in_b | input | W | Operand B word |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_word | output | W | Result word |

## Verification
The assertions rely on two conditions: the block is reset before the first transfer, and only `out_ready` decides whether the pipeline drains. This holds because the pipeline's only feedback runs from its last stage. The assertions make no assumption about the log fields of words whose flag is clear, and the stimulus deliberately puts non-zero garbage there to show that it passes through or is dropped as R3 and R4 state. The stimulus changes inputs only away from the clock edge. It toggles `out_ready` in a fixed pattern, so that stalls land on both single results and full pipelines.

// File: rtl/lns_add_pkg.sv
`timescale 1ns/1ps
package lns_add_pkg;

  // Selects how the correction term is formed inside each table section.
  typedef enum logic {
    CORR_TABLE  = 1'b0,  // section value only
    CORR_INTERP = 1'b1   // section value minus slope * offset
  } corr_mode_e;

  localparam real LN2 = 0.6931471805599453;

  // log2(1 + 2^-x), used only at elaboration to fill tables.
  function automatic real lns_corr_real(real x);
    return $ln(1.0 + $exp(-x * LN2)) / LN2;
  endfunction

endpackage

// File: rtl/lns_add_front.sv
`timescale 1ns/1ps
// Operand classification: picks the larger logarithm, the distance and the
// zero-flag bypass.
module lns_add_front #(
  parameter int EXP_W = 7,
  parameter int MAN_W = 8
) (
  input  logic [EXP_W+MAN_W+1:0]        a_i,
  input  logic [EXP_W+MAN_W+1:0]        b_i,
  output logic                          res_sign_o,
  output logic                          res_nz_o,
  output logic                          add_corr_o,
  output logic signed [EXP_W+MAN_W-1:0] big_log_o,
  output logic [EXP_W+MAN_W-1:0]        diff_o
);
  localparam int LOG_W = EXP_W + MAN_W;
  localparam int W     = LOG_W + 2;

  logic                    nz_a, nz_b, a_ge;
  logic signed [LOG_W-1:0] la, lb;
  logic signed [LOG_W:0]   ea, eb, delta;

  always_comb begin
    nz_a  = a_i[W-2];
    nz_b  = b_i[W-2];
    la    = $signed(a_i[LOG_W-1:0]);
    lb    = $signed(b_i[LOG_W-1:0]);
    ea    = {la[LOG_W-1], la};
    eb    = {lb[LOG_W-1], lb};
    a_ge  = (la >= lb);
    delta = a_ge ? (ea - eb) : (eb - ea);

    res_sign_o = 1'b0;
    res_nz_o   = 1'b0;
    add_corr_o = 1'b0;
    big_log_o  = '0;
    diff_o     = '0;
    unique case ({nz_a, nz_b})
      2'b11: begin
        res_nz_o   = 1'b1;
        add_corr_o = 1'b1;
        big_log_o  = a_ge ? la : lb;
        res_sign_o = a_ge ? a_i[W-1] : b_i[W-1];
        diff_o     = LOG_W'(delta);
      end
      2'b10: begin
        res_nz_o   = 1'b1;
        big_log_o  = la;
        res_sign_o = a_i[W-1];
      end
      2'b01: begin
        res_nz_o   = 1'b1;
        big_log_o  = lb;
        res_sign_o = b_i[W-1];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lns_add_corr.sv
`timescale 1ns/1ps
// Correction log2(1+2^-d) from a sectioned table, optionally interpolated.
module lns_add_corr
  import lns_add_pkg::*;
#(
  parameter int         MAN_W = 8,
  parameter int         LOG_W = 15,
  parameter int         SEC_W = 6,
  parameter int         GUARD = 4,
  parameter corr_mode_e MODE  = CORR_INTERP
) (
  input  logic [LOG_W-1:0] diff_i,
  output logic [MAN_W:0]   corr_o
);
  localparam int CUT_W  = $clog2(MAN_W + 2);
  localparam int D_W    = CUT_W + MAN_W;
  localparam int OFF_W  = D_W - SEC_W;
  localparam int NSEC   = 1 << SEC_W;
  localparam int VAL_W  = MAN_W + GUARD + 1;
  localparam int PROD_W = VAL_W + OFF_W;

  // Correction at section boundary k, scaled by 2^(MAN_W+GUARD).
  function automatic logic [VAL_W-1:0] knot(int k);
    real x;
    real f;
    int  q;
    x = real'(k) * real'(1 << OFF_W) / real'(1 << MAN_W);
    f = lns_corr_real(x);
    q = $rtoi(f * real'(1 << (MAN_W + GUARD)) + 0.5);
    return VAL_W'(q);
  endfunction

  logic [VAL_W-1:0] base_t [NSEC];
  logic [SEC_W-1:0] sec;
  logic [VAL_W-1:0] fine_g;
  logic [VAL_W-1:0] rnd;
  logic             far;

  for (genvar k = 0; k < NSEC; k++) begin : g_base
    localparam logic [VAL_W-1:0] BASE_K = knot(k);
    assign base_t[k] = BASE_K;
  end

  assign sec = diff_i[D_W-1:OFF_W];
  assign far = (diff_i >> D_W) != '0;

  if (MODE == CORR_INTERP) begin : g_interp
    logic [VAL_W-1:0]  slope_t [NSEC];
    logic [OFF_W-1:0]  off;
    logic [PROD_W-1:0] prod;
    for (genvar k = 0; k < NSEC; k++) begin : g_slope
      localparam logic [VAL_W-1:0] STEP_K = knot(k) - knot(k + 1);
      assign slope_t[k] = STEP_K;
    end
    assign off    = diff_i[OFF_W-1:0];
    assign prod   = PROD_W'(slope_t[sec]) * PROD_W'(off);
    assign fine_g = base_t[sec] - VAL_W'(prod >> OFF_W);
  end else begin : g_table
    assign fine_g = base_t[sec];
  end

  assign rnd    = fine_g + VAL_W'(1 << (GUARD - 1));
  assign corr_o = far ? '0 : (MAN_W+1)'(rnd >> GUARD);
endmodule

// File: rtl/lns_add_pipe.sv
`timescale 1ns/1ps
// Lock-step delay line: every stage moves together when adv_i is high.
module lns_add_pipe #(
  parameter int DW    = 17,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o
);
  logic          vld [DEPTH+1];
  logic [DW-1:0] dat [DEPTH+1];

  assign vld[0] = valid_i;
  assign dat[0] = data_i;

  for (genvar i = 1; i <= DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[i] <= 1'b0;
        dat[i] <= '0;
      end else if (adv_i) begin
        vld[i] <= vld[i-1];
        dat[i] <= dat[i-1];
      end
    end
  end

  assign valid_o = vld[DEPTH];
  assign data_o  = dat[DEPTH];

  // A held result must not move or vanish while the pipeline is frozen.
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !adv_i) |=> (valid_o && $stable(data_o)));
endmodule

// File: rtl/lns_add.sv
`timescale 1ns/1ps
module lns_add
  import lns_add_pkg::*;
#(
  parameter int         EXP_W = 7,
  parameter int         MAN_W = 8,
  parameter int         SEC_W = 6,
  parameter int         GUARD = 4,
  parameter int         PIPE  = 3,   // total latency in edges, at least 2
  parameter corr_mode_e MODE  = CORR_INTERP
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [EXP_W+MAN_W+1:0] in_a,
  input  logic [EXP_W+MAN_W+1:0] in_b,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [EXP_W+MAN_W+1:0] out_word
);
  localparam int LOG_W  = EXP_W + MAN_W;
  localparam int W      = LOG_W + 2;
  localparam int D_W    = $clog2(MAN_W + 2) + MAN_W;
  localparam int ONE    = 1 << MAN_W;
  localparam logic signed [LOG_W:0] MAXPOS = (LOG_W+1)'((1 << (LOG_W - 1)) - 1);

  logic                    f_sign, f_nz, f_add;
  logic signed [LOG_W-1:0] f_big;
  logic [LOG_W-1:0]        f_diff;

  logic                    s1_valid, s1_sign, s1_nz, s1_add;
  logic signed [LOG_W-1:0] s1_big;
  logic [LOG_W-1:0]        s1_diff;

  logic                    adv;
  logic [MAN_W:0]          corr;
  logic signed [LOG_W:0]   sum;
  logic                    sat;
  logic [LOG_W-1:0]        res_log;
  logic [W-1:0]            res_word;

  lns_add_front #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_front (
    .a_i        (in_a),
    .b_i        (in_b),
    .res_sign_o (f_sign),
    .res_nz_o   (f_nz),
    .add_corr_o (f_add),
    .big_log_o  (f_big),
    .diff_o     (f_diff)
  );

  // Whole pipeline moves unless the last stage holds an untaken result.
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_sign  <= 1'b0;
      s1_nz    <= 1'b0;
      s1_add   <= 1'b0;
      s1_big   <= '0;
      s1_diff  <= '0;
    end else if (adv) begin
      s1_valid <= in_valid;
      s1_sign  <= f_sign;
      s1_nz    <= f_nz;
      s1_add   <= f_add;
      s1_big   <= f_big;
      s1_diff  <= f_diff;
    end
  end

  lns_add_corr #(
    .MAN_W (MAN_W),
    .LOG_W (LOG_W),
    .SEC_W (SEC_W),
    .GUARD (GUARD),
    .MODE  (MODE)
  ) u_corr (
    .diff_i (s1_diff),
    .corr_o (corr)
  );

  always_comb begin
    sum      = {s1_big[LOG_W-1], s1_big} + $signed((LOG_W+1)'(s1_add ? corr : '0));
    sat      = sum > MAXPOS;
    res_log  = sat ? LOG_W'(MAXPOS) : sum[LOG_W-1:0];
    res_word = {s1_sign, s1_nz, res_log};
  end

  lns_add_pipe #(.DW(W), .DEPTH(PIPE - 1)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv_i   (adv),
    .valid_i (s1_valid),
    .data_i  (res_word),
    .valid_o (out_valid),
    .data_o  (out_word)
  );

  // The correction never exceeds 1.0 (value at d = 0).
  assert_corr_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_add) |-> (corr <= (MAN_W+1)'(ONE)));

  // Equal logarithms add exactly 1.0.
  assert_tie_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_add && s1_diff == '0) |-> (corr == (MAN_W+1)'(ONE)));

  // Beyond the table span the correction vanishes.
  assert_far_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_add && (s1_diff >> D_W) != '0) |-> (corr == '0));

  // A single non-zero operand keeps its logarithm untouched.
  assert_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_nz && !s1_add) |-> (res_log == s1_big));

  // Zero results are canonical.
  assert_zero_canon_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_word[W-2]) |-> (out_word == '0));

  // The largest logarithm stays there when anything is added.
  assert_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_nz && s1_big == LOG_W'(MAXPOS)) |-> (res_log == LOG_W'(MAXPOS)));
endmodule

// File: tb/lns_add_bench.sv
`timescale 1ns/1ps
module lns_add_bench;
  localparam int  MAN_W  = 8;
  localparam int  LOG_W  = 15;
  localparam int  W      = 17;
  localparam int  PIPE   = 3;
  localparam int  MAXPOS = 16383;
  localparam int  DCUT   = 4096;
  localparam real LN2    = 0.6931471805599453;

  // flags: [3] A non-zero, [2] B non-zero, [1] A sign, [0] B sign
  localparam int NV = 14;
  localparam int VF [NV] = '{12, 12, 12, 12, 12, 12, 8, 4, 0, 14, 13, 12, 12, 12};
  localparam int VA [NV] = '{0, 512, -1000, 300, 100, 16383, 50, 50, 77, 200, 200, -16384, 5, 1000};
  localparam int VB [NV] = '{0, 256, 37, 4395, 4196, 16383, 999, 999, 88, 180, 180, -16384, 6, 1128};

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_ready, out_valid, out_ready;
  logic [W-1:0] in_a, in_b, out_word;
  int           nchk = 0;
  int           nbad = 0;
  bit           finished = 1'b0;

  always #2.5 clk = ~clk;

  lns_add u_lns_add (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word)
  );

  function automatic logic [W-1:0] mkw(bit s, bit nz, int lg);
    return {s, nz, LOG_W'(lg)};
  endfunction

  function automatic int model_code(int la, int lb);
    real a, b, hi, d, r;
    int  c;
    a  = real'(la) / 256.0;
    b  = real'(lb) / 256.0;
    hi = (a > b) ? a : b;
    d  = (a > b) ? a - b : b - a;
    r  = hi + $ln(1.0 + $exp(-d * LN2)) / LN2;
    c  = $rtoi($floor(r * 256.0 + 0.5));
    if (c > MAXPOS) c = MAXPOS;
    return c;
  endfunction

  task automatic report(bit ok, string tag, string what, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  endtask

  task automatic check_vec(int i, logic [W-1:0] got);
    logic [W-1:0] wa, wb;
    int           el, gl, d, tol;
    string        tag;
    wa = mkw(VF[i][1], VF[i][3], VA[i]);
    wb = mkw(VF[i][0], VF[i][2], VB[i]);
    if (VF[i][3] && VF[i][2]) begin
      el  = model_code(VA[i], VB[i]);
      gl  = int'($signed(got[LOG_W-1:0]));
      d   = (VA[i] > VB[i]) ? VA[i] - VB[i] : VB[i] - VA[i];
      tol = 1;
      tag = "R2";
      if (d == 0)            begin tol = 0; tag = "R6"; end
      if (d >= DCUT)         begin tol = 0; tag = "R5"; end
      if (el == MAXPOS)      begin tol = 0; tag = "R7"; end
      // R1: flag set, sign from the larger operand (A on tie)
      report(got[W-2] && got[W-1] == ((VA[i] >= VB[i]) ? VF[i][1] : VF[i][0]),
             "R1", $sformatf("vec %0d sign/flag", i), got[W-1:W-2],
             {1'b1 == 1'b1 ? ((VA[i] >= VB[i]) ? VF[i][1] : VF[i][0]) : 1'b0, 1'b1});
      report((gl - el <= tol) && (el - gl <= tol), tag, $sformatf("vec %0d log", i), gl, el);
    end else if (VF[i][3]) begin
      report(got == wa, "R3", $sformatf("vec %0d pass A", i), got, wa);
    end else if (VF[i][2]) begin
      report(got == wb, "R3", $sformatf("vec %0d pass B", i), got, wb);
    end else begin
      report(got == '0, "R4", $sformatf("vec %0d zero", i), got, 0);
    end
  endtask

  task automatic send_one(int i, output logic [W-1:0] got, output int lat);
    @(negedge clk);
    in_a      = mkw(VF[i][1], VF[i][3], VA[i]);
    in_b      = mkw(VF[i][0], VF[i][2], VB[i]);
    in_valid  = 1'b1;
    out_ready = 1'b1;
    @(posedge clk);
    lat = 1;
    @(negedge clk);
    in_valid = 1'b0;
    while (!out_valid && lat < 20) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    got = out_word;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nbad++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", 0, 1);
      finish_up();
    end
  end

  initial begin
    logic [W-1:0] got, held;
    int           lat, sent, got_n, cyc;
    bit           holding;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    out_ready = 1'b0;
    in_a      = '0;
    in_b      = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    report(out_valid == 1'b0, "R10", "out_valid in reset", out_valid, 0);
    report(in_ready == 1'b1, "R10", "in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    report(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);

    // Vector table, one pair at a time; R8 latency on each.
    for (int i = 0; i < NV; i++) begin
      send_one(i, got, lat);
      report(lat == PIPE, "R8", $sformatf("vec %0d latency", i), lat, PIPE);
      check_vec(i, got);
    end

    // Streaming with back-pressure: order (R8) and stall behaviour (R9).
    sent = 0; got_n = 0; cyc = 0; holding = 1'b0; held = '0;
    while (got_n < NV && cyc < 400) begin
      @(negedge clk);
      cyc++;
      if (holding)
        report(out_valid && out_word == held, "R9", "held result stable", out_word, held);
      out_ready = (cyc % 3) != 0;
      in_valid  = sent < NV;
      if (sent < NV) begin
        in_a = mkw(VF[sent][1], VF[sent][3], VA[sent]);
        in_b = mkw(VF[sent][0], VF[sent][2], VB[sent]);
      end
      #1;
      if (out_valid && !out_ready)
        report(in_ready == 1'b0, "R9", "in_ready during stall", in_ready, 0);
      if (out_valid && out_ready) begin
        check_vec(got_n, out_word);
        got_n++;
      end
      holding = out_valid && !out_ready;
      held    = out_word;
      if (in_valid && in_ready) sent++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    report(got_n == NV, "R8", "stream results delivered", got_n, NV);
    finish_up();
  end
endmodule